// File: doc/BRIEF.md
# Device ROM Header and Entry Validator

This block checks a device ROM image as it streams past, one byte per accepted cycle, each byte carrying its position in the image. It guards the 8-byte unique ID with a CRC-8 held in byte 0 and pulls the payload length, vendor ID and model ID out of the 22-byte fixed header. Once the header passes, it follows the chain of variable-length entries that fills the rest of the image.

For each entry it reports the type, index and disabled flag through a one-cycle strobe. It stops the walk on an overrun or a malformed port entry. Port entries whose index exceeds a configured limit are passed over quietly. The caller supplies the bytes in ascending position order. Sending byte 0 starts a new image.

Top module: `drom_validator`

## Requirements
- R1: The ID check runs CRC-8 over bytes 1 to 8 in order: polynomial 0x07, seed 0xFF, MSB first, no final inversion. If the result differs from byte 0, `header_error` is set in the cycle after byte 8 is taken, and no entry is reported for that image.
- R2: `data_len` is bits 9:0 of the little-endian word at bytes 14 (low) and 15 (high). The upper six bits of byte 15 are ignored. The image size is `data_len` + 13.
- R3: If the image size is below 22, `header_error` is set after byte 15 and the walk never starts.
- R4: `vendor_id` is the little-endian word at bytes 16 and 17. `model_id` is the little-endian word at bytes 18 and 19.
- R5: If the revision byte at position 13 is greater than 2, `rev_warn` is set. The walk still proceeds normally.
- R6: Entries start at byte 22, and each one's first byte is its length. In the second byte, bits 5:0 are the index, bit 6 is the disabled flag, and bit 7 is the type (1 = port, 0 = generic). The cycle after the second byte is taken, `entry_valid` is high for one cycle with these fields and the length.
- R7: If an entry's length byte sits at the last byte of the image, `overrun_error` is set and the walk ends.
- R8: An entry length of zero sets `overrun_error` and ends the walk.
- R9: If an entry's start plus its length exceeds the image size, `overrun_error` is set and the walk ends.
- R10: A port entry whose index is greater than `max_port` produces no strobe and no error. The walk continues after it.
- R11: A port entry that is not disabled and has a length other than 8 sets `size_error` and ends the walk. A disabled port entry, or a generic entry, of any valid length is reported normally.
- R12: `walk_done` is high for exactly one cycle when the walk ends, in either of these cases:
  - the last image byte is reached, or the header itself fills the image;
  - an overrun or size error ends the walk.
  It never fires for an image that fails its header.
- R13: After reset, every flag, strobe and decoded field is zero.
- R14: Byte 0 of a new image clears `header_error`, `rev_warn`, `overrun_error` and `size_error`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte accepted this cycle |
| in_addr | input | ADDR_W | Position of the byte in the image |
| in_data | input | 8 | Byte value |
| max_port | input | 6 | Highest port index that is honoured |
| header_error | output | 1 | ID CRC mismatch or image too small |
| rev_warn | output | 1 | Revision byte above 2 |
| data_len | output | 10 | Decoded payload length |
| vendor_id | output | 16 | Decoded vendor ID |
| model_id | output | 16 | Decoded model ID |
| entry_valid | output | 1 | One-cycle strobe for a decoded entry |
| entry_type | output | 1 | 1 = port entry, 0 = generic |
| entry_disabled | output | 1 | Disabled flag of the entry |
| entry_index | output | 6 | Index of the entry |
| entry_len | output | 8 | Length byte of the entry |
| overrun_error | output | 1 | Entry chain ran off the image |
| size_error | output | 1 | Enabled port entry of wrong length |
| walk_done | output | 1 | One-cycle pulse when the walk ends |

## Verification
The bench builds the block with ADDR_W at its default of 11 bits, which covers the largest image a 10-bit length allows. It drives images of 22 to 40 bytes, short enough that every entry boundary sits a few bytes from the image end.

`max_port` is driven per case, at 10 and at 4. With 4, an index exactly at the limit and an index one above it both fall within reach, so the skip rule is exercised from both sides of its comparison. The high bits of the length word are always set to junk, so masking is tested in every image.

// File: rtl/drom_pkg.sv
package drom_pkg;
  localparam int HDR_LEN        = 22;
  localparam int LEN_BIAS       = 13;
  localparam int UID_FIRST      = 1;
  localparam int UID_LAST       = 8;
  localparam int REV_POS        = 13;
  localparam int LEN_LO_POS     = 14;
  localparam int LEN_HI_POS     = 15;
  localparam int VID_POS        = 16;
  localparam int MID_POS        = 18;
  localparam int REV_MAX        = 2;
  localparam int LEN_W          = 10;
  localparam int IDX_W          = 6;
  localparam int PORT_ENTRY_LEN = 8;
  localparam logic [7:0] CRC_POLY = 8'h07;
  localparam logic [7:0] CRC_SEED = 8'hFF;

  function automatic logic [7:0] crc8_byte(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] v;
    v = c ^ d;
    for (int i = 0; i < 8; i++) begin
      v = v[7] ? ((v << 1) ^ CRC_POLY) : (v << 1);
    end
    return v;
  endfunction
endpackage

// File: rtl/drom_crc8.sv
module drom_crc8 (
  input  logic       clk,
  input  logic       rst,
  input  logic       seed_ld,
  input  logic       upd,
  input  logic [7:0] din,
  output logic [7:0] crc_nxt
);
  import drom_pkg::*;
  logic [7:0] crc_q;

  assign crc_nxt = crc8_byte(crc_q, din);

  always_ff @(posedge clk) begin
    if (rst)          crc_q <= CRC_SEED;
    else if (seed_ld) crc_q <= CRC_SEED;
    else if (upd)     crc_q <= crc_nxt;
  end
endmodule

// File: rtl/drom_hdr.sv
module drom_hdr #(
  parameter int ADDR_W = 11
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic [ADDR_W-1:0]            in_addr,
  input  logic [7:0]                   in_data,
  input  logic [7:0]                   crc_nxt,
  output logic                         crc_ld,
  output logic                         crc_upd,
  output logic                         header_error,
  output logic                         rev_warn,
  output logic [drom_pkg::LEN_W-1:0]   data_len,
  output logic [15:0]                  vendor_id,
  output logic [15:0]                  model_id,
  output logic [ADDR_W-1:0]            img_size,
  output logic                         hdr_ok
);
  import drom_pkg::*;
  localparam logic [ADDR_W-1:0] A_ZERO  = '0;
  localparam logic [ADDR_W-1:0] A_UID0  = ADDR_W'(UID_FIRST);
  localparam logic [ADDR_W-1:0] A_UID1  = ADDR_W'(UID_LAST);
  localparam logic [ADDR_W-1:0] A_REV   = ADDR_W'(REV_POS);
  localparam logic [ADDR_W-1:0] A_LLO   = ADDR_W'(LEN_LO_POS);
  localparam logic [ADDR_W-1:0] A_LHI   = ADDR_W'(LEN_HI_POS);
  localparam logic [ADDR_W-1:0] A_VLO   = ADDR_W'(VID_POS);
  localparam logic [ADDR_W-1:0] A_VHI   = ADDR_W'(VID_POS + 1);
  localparam logic [ADDR_W-1:0] A_MLO   = ADDR_W'(MID_POS);
  localparam logic [ADDR_W-1:0] A_MHI   = ADDR_W'(MID_POS + 1);
  localparam logic [ADDR_W-1:0] A_LAST  = ADDR_W'(HDR_LEN - 1);
  localparam logic [LEN_W-1:0]  MIN_LEN = LEN_W'(HDR_LEN - LEN_BIAS);

  logic [7:0]       ref_q;
  logic [7:0]       len_lo;
  logic             active;
  logic [LEN_W-1:0] len_now;

  assign crc_ld   = in_valid && (in_addr == A_ZERO);
  assign crc_upd  = in_valid && (in_addr >= A_UID0) && (in_addr <= A_UID1);
  assign len_now  = {in_data[LEN_W-9:0], len_lo};
  assign img_size = ADDR_W'(data_len) + ADDR_W'(LEN_BIAS);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= '0; len_lo <= '0; active <= 1'b0;
      header_error <= 1'b0; rev_warn <= 1'b0; hdr_ok <= 1'b0;
      data_len <= '0; vendor_id <= '0; model_id <= '0;
    end else begin
      hdr_ok <= 1'b0;
      if (in_valid) begin
        if (in_addr == A_ZERO) begin
          ref_q <= in_data; active <= 1'b1;
          header_error <= 1'b0; rev_warn <= 1'b0;
          data_len <= '0; vendor_id <= '0; model_id <= '0;
        end else if (active) begin
          case (in_addr)
            A_UID1: if (crc_nxt != ref_q) begin
              header_error <= 1'b1; active <= 1'b0;
            end
            A_REV: rev_warn <= (in_data > 8'(REV_MAX));
            A_LLO: len_lo <= in_data;
            A_LHI: begin
              data_len <= len_now;
              if (len_now < MIN_LEN) begin
                header_error <= 1'b1; active <= 1'b0;
              end
            end
            A_VLO: vendor_id[7:0]  <= in_data;
            A_VHI: vendor_id[15:8] <= in_data;
            A_MLO: model_id[7:0]   <= in_data;
            A_MHI: model_id[15:8]  <= in_data;
            A_LAST: begin hdr_ok <= 1'b1; active <= 1'b0; end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/drom_walk.sv
module drom_walk #(
  parameter int ADDR_W = 11
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [ADDR_W-1:0]          in_addr,
  input  logic [7:0]                 in_data,
  input  logic [drom_pkg::IDX_W-1:0] max_port,
  input  logic [ADDR_W-1:0]          img_size,
  input  logic                       hdr_ok,
  output logic                       entry_valid,
  output logic                       entry_type,
  output logic                       entry_disabled,
  output logic [drom_pkg::IDX_W-1:0] entry_index,
  output logic [7:0]                 entry_len,
  output logic                       overrun_error,
  output logic                       size_error,
  output logic                       walk_done
);
  import drom_pkg::*;
  localparam logic [ADDR_W-1:0] A_FIRST = ADDR_W'(HDR_LEN);

  logic              walking, hdr_exp, pend, live, last_byte, len_bad;
  logic              is_port, is_dis, skip, bad_size;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] nxt;
  logic [7:0]        elen;
  logic [ADDR_W:0]   end_sum;

  assign live      = walking || hdr_ok;
  assign last_byte = (in_addr == img_size - 1'b1);
  assign end_sum   = {1'b0, in_addr} + (ADDR_W + 1)'(in_data);
  assign len_bad   = last_byte || (in_data == 8'd0) || (end_sum > {1'b0, img_size});
  assign is_port   = in_data[7];
  assign is_dis    = in_data[6];
  assign idx       = in_data[IDX_W-1:0];
  assign skip      = is_port && (idx > max_port);
  assign bad_size  = is_port && !is_dis && (elen != 8'(PORT_ENTRY_LEN));

  always_ff @(posedge clk) begin
    if (rst) begin
      walking <= 1'b0; hdr_exp <= 1'b0; pend <= 1'b0; nxt <= A_FIRST; elen <= '0;
      entry_valid <= 1'b0; entry_type <= 1'b0; entry_disabled <= 1'b0;
      entry_index <= '0; entry_len <= '0;
      overrun_error <= 1'b0; size_error <= 1'b0; walk_done <= 1'b0;
    end else begin
      entry_valid <= 1'b0;
      walk_done   <= pend;
      pend        <= 1'b0;
      if (in_valid && in_addr == '0) begin
        walking <= 1'b0; hdr_exp <= 1'b0; nxt <= A_FIRST;
        overrun_error <= 1'b0; size_error <= 1'b0;
      end else begin
        if (hdr_ok) walking <= 1'b1;
        if (hdr_ok && img_size == A_FIRST) begin
          walking <= 1'b0; pend <= 1'b1;
        end else if (live && in_valid) begin
          if (in_addr == nxt) begin
            if (len_bad) begin
              overrun_error <= 1'b1; walking <= 1'b0; pend <= 1'b1;
            end else begin
              elen <= in_data; nxt <= in_addr + ADDR_W'(in_data); hdr_exp <= 1'b1;
            end
          end else begin
            if (hdr_exp) begin
              hdr_exp <= 1'b0;
              if (!skip) begin
                if (bad_size) begin
                  size_error <= 1'b1;
                end else begin
                  entry_valid <= 1'b1; entry_type <= is_port; entry_disabled <= is_dis;
                  entry_index <= idx; entry_len <= elen;
                end
              end
            end
            if (last_byte || (hdr_exp && !skip && bad_size)) begin
              walking <= 1'b0; pend <= 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/drom_validator.sv
module drom_validator #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [7:0]        in_data,
  input  logic [5:0]        max_port,
  output logic              header_error,
  output logic              rev_warn,
  output logic [9:0]        data_len,
  output logic [15:0]       vendor_id,
  output logic [15:0]       model_id,
  output logic              entry_valid,
  output logic              entry_type,
  output logic              entry_disabled,
  output logic [5:0]        entry_index,
  output logic [7:0]        entry_len,
  output logic              overrun_error,
  output logic              size_error,
  output logic              walk_done
);
  logic              crc_ld, crc_upd, hdr_ok;
  logic [7:0]        crc_nxt;
  logic [ADDR_W-1:0] img_size;

  drom_crc8 u_crc (
    .clk(clk), .rst(rst), .seed_ld(crc_ld), .upd(crc_upd), .din(in_data), .crc_nxt(crc_nxt)
  );

  drom_hdr #(.ADDR_W(ADDR_W)) u_hdr (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr), .in_data(in_data),
    .crc_nxt(crc_nxt), .crc_ld(crc_ld), .crc_upd(crc_upd),
    .header_error(header_error), .rev_warn(rev_warn), .data_len(data_len),
    .vendor_id(vendor_id), .model_id(model_id), .img_size(img_size), .hdr_ok(hdr_ok)
  );

  drom_walk #(.ADDR_W(ADDR_W)) u_walk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr), .in_data(in_data),
    .max_port(max_port), .img_size(img_size), .hdr_ok(hdr_ok),
    .entry_valid(entry_valid), .entry_type(entry_type), .entry_disabled(entry_disabled),
    .entry_index(entry_index), .entry_len(entry_len),
    .overrun_error(overrun_error), .size_error(size_error), .walk_done(walk_done)
  );
endmodule

// File: rtl/drom_validator_chk.sv
module drom_validator_chk (
  input logic clk,
  input logic rst,
  input logic header_error,
  input logic entry_valid,
  input logic walk_done,
  input logic overrun_error,
  input logic size_error
);
  // R6
  entry_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    entry_valid |=> !entry_valid);
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    walk_done |=> !walk_done);
  // R1
  hdr_err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    header_error |-> (!entry_valid && !walk_done));
  // R7
  ovr_alone_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun_error) |-> !size_error);
  // R11
  size_alone_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(size_error) |-> !overrun_error);
  // R9
  ovr_ends_walk_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun_error) |=> walk_done);
endmodule

bind drom_validator drom_validator_chk u_chk (
  .clk(clk), .rst(rst), .header_error(header_error), .entry_valid(entry_valid),
  .walk_done(walk_done), .overrun_error(overrun_error), .size_error(size_error)
);

// File: tb/drom_validator_test.sv
module drom_validator_test;
  localparam int ADDR_W = 11;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [ADDR_W-1:0] in_addr = '0;
  logic [7:0] in_data = '0;
  logic [5:0] max_port = 6'd10;
  logic header_error, rev_warn, entry_valid, entry_type, entry_disabled;
  logic overrun_error, size_error, walk_done;
  logic [9:0] data_len;
  logic [15:0] vendor_id, model_id;
  logic [5:0] entry_index;
  logic [7:0] entry_len;

  always #10 clk = ~clk;

  drom_validator #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr), .in_data(in_data),
    .max_port(max_port), .header_error(header_error), .rev_warn(rev_warn),
    .data_len(data_len), .vendor_id(vendor_id), .model_id(model_id),
    .entry_valid(entry_valid), .entry_type(entry_type), .entry_disabled(entry_disabled),
    .entry_index(entry_index), .entry_len(entry_len), .overrun_error(overrun_error),
    .size_error(size_error), .walk_done(walk_done)
  );

  typedef struct packed {
    logic [7:0] sz; logic [7:0] rev; logic bad; logic [5:0] maxp; logic [1:0] ne;
    logic [7:0] l0; logic [7:0] h0; logic [7:0] l1; logic [7:0] h1; logic [7:0] l2; logic [7:0] h2;
    logic xh; logic xw; logic xo; logic xs; logic [1:0] xv; logic xd;
  } vec_t;

  localparam vec_t VECS [0:11] = '{
    // R6 clean chain of three entries
    '{8'd40,8'd1,1'b0,6'd10,2'd3,8'd6,8'h01,8'd8,8'h83,8'd4,8'h02,1'b0,1'b0,1'b0,1'b0,2'd3,1'b1},
    // R1 bad ID CRC
    '{8'd40,8'd1,1'b1,6'd10,2'd3,8'd6,8'h01,8'd8,8'h83,8'd4,8'h02,1'b1,1'b0,1'b0,1'b0,2'd0,1'b0},
    // R3 image smaller than header
    '{8'd21,8'd1,1'b0,6'd10,2'd0,8'd0,8'h00,8'd0,8'h00,8'd0,8'h00,1'b1,1'b0,1'b0,1'b0,2'd0,1'b0},
    // R12 header fills image
    '{8'd22,8'd1,1'b0,6'd10,2'd0,8'd0,8'h00,8'd0,8'h00,8'd0,8'h00,1'b0,1'b0,1'b0,1'b0,2'd0,1'b1},
    // R5 revision 3 warns, walk continues
    '{8'd30,8'd3,1'b0,6'd10,2'd1,8'd8,8'h01,8'd0,8'h00,8'd0,8'h00,1'b0,1'b1,1'b0,1'b0,2'd1,1'b1},
    // R9 entry runs past end
    '{8'd30,8'd1,1'b0,6'd10,2'd1,8'd9,8'h01,8'd0,8'h00,8'd0,8'h00,1'b0,1'b0,1'b1,1'b0,2'd0,1'b1},
    // R8 zero length
    '{8'd30,8'd1,1'b0,6'd10,2'd1,8'd0,8'h01,8'd0,8'h00,8'd0,8'h00,1'b0,1'b0,1'b1,1'b0,2'd0,1'b1},
    // R7 entry starting on last byte
    '{8'd29,8'd1,1'b0,6'd10,2'd2,8'd6,8'h01,8'd4,8'h02,8'd0,8'h00,1'b0,1'b0,1'b1,1'b0,2'd1,1'b1},
    // R10 port index above limit skipped
    '{8'd31,8'd1,1'b0,6'd4,2'd2,8'd5,8'h85,8'd4,8'h02,8'd0,8'h00,1'b0,1'b0,1'b0,1'b0,2'd1,1'b1},
    // R11 enabled port of length 6
    '{8'd30,8'd1,1'b0,6'd10,2'd1,8'd6,8'h82,8'd0,8'h00,8'd0,8'h00,1'b0,1'b0,1'b0,1'b1,2'd0,1'b1},
    // R11 disabled port of length 3 accepted
    '{8'd25,8'd1,1'b0,6'd10,2'd1,8'd3,8'hC2,8'd0,8'h00,8'd0,8'h00,1'b0,1'b0,1'b0,1'b0,2'd1,1'b1},
    // R10 index equal to limit kept
    '{8'd30,8'd1,1'b0,6'd4,2'd1,8'd8,8'h84,8'd0,8'h00,8'd0,8'h00,1'b0,1'b0,1'b0,1'b0,2'd1,1'b1}
  };

  int n_tests = 0, n_fail = 0, n_valid = 0, n_done = 0;
  logic l_type, l_dis;
  logic [5:0] l_idx;
  logic [7:0] l_len;
  logic [7:0] img [0:63];

  always @(negedge clk) begin
    if (!rst && entry_valid) begin
      n_valid++; l_type = entry_type; l_dis = entry_disabled; l_idx = entry_index; l_len = entry_len;
    end
    if (!rst && walk_done) n_done++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] v = c ^ d;
    for (int b = 0; b < 8; b++) v = {v[6:0], 1'b0} ^ (v[7] ? 8'h07 : 8'h00);
    return v;
  endfunction

  task automatic build(input vec_t v);
    logic [7:0] c = 8'hFF;
    logic [9:0] dl = 10'(v.sz - 8'd13);
    int pos = 22;
    logic [7:0] ls [3];
    logic [7:0] hs [3];
    ls[0] = v.l0; ls[1] = v.l1; ls[2] = v.l2;
    hs[0] = v.h0; hs[1] = v.h1; hs[2] = v.h2;
    for (int k = 0; k < 64; k++) img[k] = 8'hA5;
    for (int k = 1; k <= 8; k++) begin
      img[k] = 8'(8'h30 + 7 * k);
      c = ref_crc(c, img[k]);
    end
    img[0] = v.bad ? (c ^ 8'h01) : c;
    img[13] = v.rev;
    img[14] = dl[7:0];
    img[15] = {6'h2A, dl[9:8]};
    img[16] = 8'hB2; img[17] = 8'hA1; img[18] = 8'hD4; img[19] = 8'hC3;
    for (int e = 0; e < int'(v.ne); e++) begin
      if (pos < 63) begin img[pos] = ls[e]; img[pos+1] = hs[e]; end
      if (ls[e] == 0) break;
      pos += ls[e];
    end
  endtask

  task automatic send(input int nbytes);
    for (int k = 0; k < nbytes; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_addr = ADDR_W'(k); in_data = img[k];
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic run_vec(input vec_t v);
    @(negedge clk);
    n_valid = 0; n_done = 0; max_port = v.maxp;
    build(v);
    send((v.sz < 22) ? 22 : int'(v.sz));
    check(header_error == v.xh, "R1/R3 header_error", header_error, v.xh);
    check(rev_warn == v.xw, "R5 rev_warn", rev_warn, v.xw);
    check(overrun_error == v.xo, "R7/R8/R9 overrun_error", overrun_error, v.xo);
    check(size_error == v.xs, "R11 size_error", size_error, v.xs);
    check(n_valid == int'(v.xv), "R6/R10 entry count", n_valid, v.xv);
    check(n_done == int'(v.xd), "R12 walk_done count", n_done, v.xd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    check(!header_error && !rev_warn && !overrun_error && !size_error, "R13 flags", 0, 0);
    check(!entry_valid && !walk_done && data_len == 0 && vendor_id == 0, "R13 outputs", 0, 0);

    for (int i = 0; i < 12; i++) begin
      run_vec(VECS[i]);
      if (i == 0) begin
        check(data_len == 10'd27, "R2 data_len", data_len, 27);
        check(vendor_id == 16'hA1B2, "R4 vendor_id", vendor_id, 16'hA1B2);
        check(model_id == 16'hC3D4, "R4 model_id", model_id, 16'hC3D4);
        check(l_type == 1'b0 && l_idx == 6'd2 && l_len == 8'd4, "R6 last entry", l_idx, 2);
      end
      if (i == 10) begin
        check(l_type && l_dis && l_idx == 6'd2 && l_len == 8'd3, "R6 disabled port fields",
              {l_type, l_dis, l_idx}, 8'hC2);
      end
      if (i == 11) check(l_type && l_idx == 6'd4 && l_len == 8'd8, "R10 boundary index", l_idx, 4);
    end

    // R14 restart clears error flags
    run_vec(VECS[9]);
    build(VECS[0]);
    @(negedge clk);
    in_valid = 1'b1; in_addr = '0; in_data = img[0];
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check(!size_error && !overrun_error, "R14 walk flags cleared", size_error, 0);
    run_vec(VECS[1]);
    @(negedge clk);
    in_valid = 1'b1; in_addr = '0; in_data = img[0];
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check(!header_error, "R14 header flag cleared", header_error, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule